// File: doc/BRIEF.md
# Power-On Reset Delay Timer

This block stretches the core reset after a power or wake event. It runs on its own slow, free-running timer clock. Whenever one of its trigger sources fires, it raises `core_rst_hold`, counts a fixed number of timer clock cycles, and then drops the hold. In the same cycle it gives a single-cycle `por_done` pulse. The interval gives the supply rail and the main oscillator time to settle before the core starts fetching.

There are three trigger sources. The first is a rising edge of the power-good level, which also covers recovery from low-voltage standby. The second is a watchdog expiry event. The third is a stop-mode wake event, which counts only when the stop-mode configuration enables it. A second configuration bit lets a stop wake skip the delay. A skipped wake gives only the `por_done` pulse. The watchdog and power-good sources always run the full interval, whatever the configuration bits say, including a watchdog expiry that happens while the part is stopped.

All inputs are synchronous to `tclk`. The delay is set by `TCLK_KHZ` and `DELAY_US`. The defaults (32 kHz and 5000 us) give 160 cycles, which is about 5 ms.

Top module: `por_delay_timer`

## Requirements
- R1: After `rst_n` is released with `pwr_ok` high, `core_rst_hold` reads 1 and `por_done` reads 0. `core_rst_hold` falls after exactly DELAY timer clock edges.
- R2: While `pwr_ok` is 0, `core_rst_hold` is 1 and the interval count is held at zero. A 0-to-1 transition of `pwr_ok` starts a full interval.
- R3: A `wdt_expire` pulse starts a full interval whatever the values of `smr_por_en` and `smr_bypass`.
- R4: A `stop_wake` pulse with `smr_por_en`=1 and `smr_bypass`=0 starts a full interval.
- R5: A `stop_wake` pulse with `smr_por_en`=0 has no effect. `core_rst_hold` and `por_done` stay 0.
- R6: When the block is idle, a `stop_wake` pulse with `smr_por_en`=1 and `smr_bypass`=1 leaves `core_rst_hold` at 0. It gives `por_done`=1 for exactly the one cycle after the wake edge.
- R7: A bypassed stop wake that arrives while an interval is running is ignored. The release cycle does not change and no extra `por_done` pulse appears.
- R8: A full trigger that arrives during a running interval restarts the count. The hold falls DELAY edges after the last trigger.
- R9: `por_done` is 1 for exactly one cycle, and that cycle is the first one in which `core_rst_hold` is 0 after an interval.
- R10: If a full trigger and a bypassed stop wake arrive in the same cycle, the full trigger wins and a full interval runs.
- R11: DELAY equals TCLK_KHZ*DELAY_US/1000 timer cycles. The defaults give 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Free-running timer clock |
| rst_n | input | 1 | Asynchronous active-low initial reset of the timer logic |
| pwr_ok | input | 1 | Supply-good level; 1 means the supply is OK |
| stop_wake | input | 1 | One-cycle stop-mode recovery event |
| wdt_expire | input | 1 | One-cycle watchdog expiry event |
| smr_por_en | input | 1 | Stop-mode configuration: a stop wake runs the timer |
| smr_bypass | input | 1 | Stop-mode configuration: a stop wake skips the delay |
| core_rst_hold | output | 1 | Holds the core in reset while 1 |
| por_done | output | 1 | One-cycle pulse when the core may start |

## Verification
The same full-interval check is applied to each trigger source on its own: reset release, a power-good rise after a dip, a watchdog expiry with the configuration bits set against it, and an enabled stop wake. A source routed the wrong way shows up as a missing or mis-timed release. Stop wakes are tried under all three configurations. This tells apart the ignored, delayed and bypassed cases. Colliding patterns show whether the count restarts or stays put: a second trigger mid-count, a bypassed wake mid-count, and a watchdog expiry in the same cycle as a bypassed wake. A per-cycle behavioural model then compares both outputs on every cycle.

// File: rtl/por_pkg.sv
package por_pkg;

  // Number of timer clock cycles for a delay given in microseconds.
  function automatic int unsigned por_cycles(input int unsigned khz,
                                             input int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    if (c < 2) c = 2;
    return c;
  endfunction

  // Counter width able to hold values 0..cycles.
  function automatic int unsigned por_cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

  typedef enum logic [1:0] {
    TRIG_NONE   = 2'd0,
    TRIG_FULL   = 2'd1,
    TRIG_BYPASS = 2'd2
  } trig_kind_e;

endpackage

// File: rtl/por_trig_decode.sv
module por_trig_decode
  import por_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       stop_wake,
  input  logic       wdt_expire,
  input  logic       smr_por_en,
  input  logic       smr_bypass,
  output trig_kind_e kind,
  output logic       pwr_rise
);

  logic pwr_prev_q;
  logic stop_full;
  logic stop_skip;

  // Previous supply level; starts as "good" so a reset with the supply
  // already up does not count as a fresh rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_prev_q <= 1'b1;
    else        pwr_prev_q <= pwr_ok;
  end

  assign pwr_rise  = pwr_ok & ~pwr_prev_q;
  assign stop_full = stop_wake & smr_por_en & ~smr_bypass;
  assign stop_skip = stop_wake & smr_por_en &  smr_bypass;

  // A full-delay source outranks a bypassed stop wake.
  always_comb begin
    if (pwr_rise || wdt_expire || stop_full) kind = TRIG_FULL;
    else if (stop_skip)                       kind = TRIG_BYPASS;
    else                                      kind = TRIG_NONE;
  end

endmodule

// File: rtl/por_interval_counter.sv
module por_interval_counter #(
  parameter int unsigned DELAY_CYC = 160,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);

  localparam logic [CW-1:0] LAST_VAL = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign last = run & (cnt_q == LAST_VAL);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear)        cnt_q <= '0;
    else if (last)         cnt_q <= '0;
    else if (run)          cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/por_release_ctl.sv
module por_release_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic start_full,
  input  logic start_skip,
  input  logic expire,
  output logic hold,
  output logic done
);

  logic hold_q;
  logic done_q;
  logic hold_d;
  logic done_d;

  always_comb begin
    hold_d = hold_q;
    done_d = 1'b0;
    if (!pwr_ok || start_full) begin
      hold_d = 1'b1;
    end else if (expire) begin
      hold_d = 1'b0;
      done_d = 1'b1;
    end else if (start_skip && !hold_q) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end

  assign hold = hold_q;
  assign done = done_q;

endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer
  import por_pkg::*;
#(
  parameter int unsigned TCLK_KHZ = 32,
  parameter int unsigned DELAY_US = 5000
) (
  input  logic tclk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic stop_wake,
  input  logic wdt_expire,
  input  logic smr_por_en,
  input  logic smr_bypass,
  output logic core_rst_hold,
  output logic por_done
);

  localparam int unsigned DELAY_CYC = por_cycles(TCLK_KHZ, DELAY_US);
  localparam int unsigned CW        = por_cnt_width(DELAY_CYC);

  trig_kind_e    kind;
  logic          pwr_rise;
  logic          trig_full;
  logic          trig_bypass;
  logic          cnt_clear;
  logic          cnt_run;
  logic          cnt_terminal;
  logic [CW-1:0] cnt_q;

  por_trig_decode u_dec (
    .clk        (tclk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .stop_wake  (stop_wake),
    .wdt_expire (wdt_expire),
    .smr_por_en (smr_por_en),
    .smr_bypass (smr_bypass),
    .kind       (kind),
    .pwr_rise   (pwr_rise)
  );

  assign trig_full   = (kind == TRIG_FULL);
  assign trig_bypass = (kind == TRIG_BYPASS) & pwr_ok;
  assign cnt_clear   = trig_full | ~pwr_ok;
  assign cnt_run     = core_rst_hold & pwr_ok & ~trig_full;

  por_interval_counter #(
    .DELAY_CYC (DELAY_CYC),
    .CW        (CW)
  ) u_cnt (
    .clk   (tclk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .run   (cnt_run),
    .cnt   (cnt_q),
    .last  (cnt_terminal)
  );

  por_release_ctl u_rel (
    .clk        (tclk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .start_full (trig_full),
    .start_skip (trig_bypass),
    .expire     (cnt_terminal),
    .hold       (core_rst_hold),
    .done       (por_done)
  );

endmodule

// File: rtl/por_delay_timer_chk.sv
module por_delay_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_ok,
  input logic          pwr_rise,
  input logic          trig_full,
  input logic          trig_bypass,
  input logic [CW-1:0] cnt,
  input logic          hold_o,
  input logic          done_o
);

  // R2
  pwr_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (hold_o && cnt == '0));

  // R2
  pwr_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rise |=> (hold_o && !done_o));

  // R8
  full_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_full |=> (hold_o && cnt == '0 && !done_o));

  // R9
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> done_o);

  // R9
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !hold_o);

  // R6
  bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_bypass && !hold_o) |=> (!hold_o && done_o));

  // R7
  bypass_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_bypass && hold_o && !trig_full) |=> $stable(hold_o) || done_o);

endmodule

bind por_delay_timer por_delay_timer_chk #(.CW(CW)) u_chk (
  .clk         (tclk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .pwr_rise    (pwr_rise),
  .trig_full   (trig_full),
  .trig_bypass (trig_bypass),
  .cnt         (cnt_q),
  .hold_o      (core_rst_hold),
  .done_o      (por_done)
);

// File: tb/por_delay_timer_bench.sv
`timescale 1ns/1ps
module por_delay_timer_bench;

  localparam int KHZ = 32;
  localparam int US  = 500;
  localparam int DLY = (KHZ * US) / 1000; // R11: own restatement, 16

  logic tclk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic stop_wake = 1'b0;
  logic wdt_expire = 1'b0;
  logic smr_por_en = 1'b0;
  logic smr_bypass = 1'b0;
  logic core_rst_hold;
  logic por_done;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference
  bit m_hold = 1'b1;
  bit m_done = 1'b0;
  bit m_prev = 1'b1;
  int m_elapsed = 0;

  always #2.5 tclk = ~tclk;

  por_delay_timer #(.TCLK_KHZ(KHZ), .DELAY_US(US)) u_por_delay_timer (
    .tclk(tclk), .rst_n(rst_n), .pwr_ok(pwr_ok), .stop_wake(stop_wake),
    .wdt_expire(wdt_expire), .smr_por_en(smr_por_en), .smr_bypass(smr_bypass),
    .core_rst_hold(core_rst_hold), .por_done(por_done)
  );

  always @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 1'b1; m_done = 1'b0; m_prev = 1'b1; m_elapsed = 0;
    end else begin
      bit full_t;
      full_t = (pwr_ok && !m_prev) || wdt_expire ||
               (stop_wake && smr_por_en && !smr_bypass);
      if (!pwr_ok || full_t) begin
        m_hold = 1'b1; m_elapsed = 0; m_done = 1'b0;
      end else if (m_hold) begin
        m_elapsed++;
        if (m_elapsed == DLY) begin m_hold = 1'b0; m_done = 1'b1; m_elapsed = 0; end
        else m_done = 1'b0;
      end else begin
        m_done = stop_wake && smr_por_en && smr_bypass;
      end
      m_prev = pwr_ok;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge tclk) begin
    if (rst_n) begin
      check(cur_req, "hold vs model", core_rst_hold, m_hold);
      check(cur_req, "done vs model", por_done, m_done);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge tclk);
  endtask

  task automatic pulse_wdt();
    wdt_expire = 1'b1; @(negedge tclk); wdt_expire = 1'b0;
  endtask

  task automatic pulse_stop(input bit en, input bit byp);
    smr_por_en = en; smr_bypass = byp; stop_wake = 1'b1;
    @(negedge tclk); stop_wake = 1'b0;
  endtask

  // counts samples with hold high, then checks the release and done pulse
  task automatic measure(input string req, input int exp);
    int n = 0;
    while (core_rst_hold && n < 1000) begin n++; @(negedge tclk); end
    check(req, "hold length", n, exp);
    check("R9", "done at release", por_done, 1);
    @(negedge tclk);
    check("R9", "done one cycle", por_done, 0);
  endtask

  initial begin
    step(3);
    check("R1", "reset hold", core_rst_hold, 1);
    check("R1", "reset done", por_done, 0);
    rst_n = 1'b1;
    cur_req = "R1";
    measure("R11", DLY);
    step(3);

    cur_req = "R5";
    pulse_stop(1'b0, 1'b1);
    check("R5", "hold after disabled wake", core_rst_hold, 0);
    check("R5", "done after disabled wake", por_done, 0);
    step(3);
    check("R5", "hold later", core_rst_hold, 0);

    cur_req = "R6";
    pulse_stop(1'b1, 1'b1);
    check("R6", "bypass hold", core_rst_hold, 0);
    check("R6", "bypass done", por_done, 1);
    step(1);
    check("R6", "bypass done width", por_done, 0);
    step(2);

    cur_req = "R4";
    pulse_stop(1'b1, 1'b0);
    measure("R4", DLY);
    step(2);

    cur_req = "R3";
    smr_por_en = 1'b0; smr_bypass = 1'b1;
    pulse_wdt();
    measure("R3", DLY);
    step(2);

    cur_req = "R8";
    pulse_wdt();
    step(5);
    pulse_wdt();
    measure("R8", DLY);
    step(2);

    cur_req = "R7";
    pulse_wdt();
    step(3);
    pulse_stop(1'b1, 1'b1);
    measure("R7", DLY - 4);
    step(2);

    cur_req = "R10";
    smr_por_en = 1'b1; smr_bypass = 1'b1;
    wdt_expire = 1'b1; stop_wake = 1'b1;
    @(negedge tclk);
    wdt_expire = 1'b0; stop_wake = 1'b0;
    check("R10", "full wins hold", core_rst_hold, 1);
    check("R10", "full wins done", por_done, 0);
    measure("R10", DLY);
    step(2);

    cur_req = "R2";
    pwr_ok = 1'b0;
    step(5);
    check("R2", "hold in power fail", core_rst_hold, 1);
    pwr_ok = 1'b1;
    @(negedge tclk);
    measure("R2", DLY);
    step(2);

    // R2: dip in mid-count restarts from the rise
    pulse_wdt();
    step(4);
    pwr_ok = 1'b0; step(2); pwr_ok = 1'b1;
    @(negedge tclk);
    measure("R2", DLY);
    step(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge tclk); cyc++; end
    fails++; tests++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule